// File: doc/BRIEF.md
# Self-Clocked Serial Register Write Port

This block is the device-side receive path for serial register writes in the mode where the device supplies the serial clock. The host pulls an active-low frame strobe low. The block detects that falling edge, enables its clock output and generates a clock by dividing the system clock. It shifts in one 24-bit word, most significant bit first, taking each bit on a rising edge of the generated clock. An address select input, latched when the transfer starts, chooses the target. Low selects the control register and high selects the calibration register.

When the last bit has been taken in, the whole word is written into the selected register in a single system-clock cycle. The clock output then goes low at its next falling point, and one cycle later the block drops the clock's output enable so that an external pull-up owns the line. After that, the host must produce a new falling edge on the frame strobe to start another word.

Top module: `serial_wr_port`

## Requirements
- R1: During and right after a synchronous active-high reset, `sclk_oe` and `sclk_o` are 0 and both `ctrl_reg` and `cal_reg` read 0.
- R2: A transfer starts only on a high-to-low change of `frame_n` seen after reset. If `frame_n` is held low through the release of reset, no clock is produced.
- R3: While a transfer runs, the generated clock has a period of `DIV` system cycles and is high for `DIV - DIV/2` cycles in each period.
- R4: A transfer produces exactly 24 rising edges of `sclk_o`. `sdi` is taken on each rising edge, the first bit being the most significant bit of the word.
- R5: `addr_sel` sampled at the start edge chooses the target: 0 writes `ctrl_reg` and 1 writes `cal_reg`. The other register keeps its value.
- R6: The target register keeps its old value until the 24th bit is taken. It then changes in one cycle to the complete word.
- R7: After the 24th rising edge, `sclk_o` goes low `DIV - DIV/2` cycles later and `sclk_oe` is deasserted one cycle after that. Whenever `sclk_oe` is 0, `sclk_o` is 0.
- R8: Changes of `frame_n` during a transfer, including a new falling edge, have no effect. Holding `frame_n` low after a word ends does not start another word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low transmit-frame strobe; its falling edge starts a word |
| addr_sel | input | 1 | Target select: 0 control, 1 calibration |
| sdi | input | 1 | Serial data input, MSB first |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock line |
| ctrl_reg | output | 24 | Control register contents |
| cal_reg | output | 24 | Calibration register contents |

## Verification
The hardest case to reach is a falling edge on the frame strobe that arrives while a word is already being shifted. The port must ignore it. It must neither restart the bit count nor let that edge start a second word after the first one ends. To reach it, the driver task pulls the strobe high after the tenth generated rising edge and low again after the fifteenth. The scoreboard then expects one intact word and no extra clock edges. The driver also holds the strobe low through reset, and after every word, to confirm that only a real high-to-low transition starts a transfer.

// File: rtl/wrsp_pkg.sv
package wrsp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2,
    ST_STOP = 2'd3
  } wr_state_t;
endpackage

// File: rtl/wrsp_sclk_gen.sv
module wrsp_sclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk_o,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] RISE_AT = CW'(DIV / 2 - 1);
  localparam logic [CW-1:0] FALL_AT = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign rise_stb = run && (cnt_q == RISE_AT);
  assign fall_stb = run && (cnt_q == FALL_AT);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else begin
      cnt_q <= fall_stb ? '0 : cnt_q + 1'b1;
      if (rise_stb)
        sclk_o <= 1'b1;
      else if (fall_stb)
        sclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wrsp_shifter.sv
module wrsp_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         sdi,
  output logic [W-1:0] word_next,
  output logic         last
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

  logic [W-2:0]  sh_q;
  logic [BW-1:0] bit_q;

  assign word_next = {sh_q, sdi};
  assign last      = shift_en && (bit_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (clear) begin
      bit_q <= '0;
    end else if (shift_en) begin
      sh_q  <= word_next[W-2:0];
      bit_q <= bit_q + 1'b1;
    end
  end
endmodule

// File: rtl/wrsp_reg_bank.sv
module wrsp_reg_bank #(
  parameter int W    = 24,
  parameter int NREG = 2,
  parameter int SW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [SW-1:0]            sel,
  input  logic [W-1:0]             data,
  output logic [NREG-1:0][W-1:0]   regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_en && (sel == SW'(i)))
        regs[i] <= data;
    end
  end
endmodule

// File: rtl/serial_wr_port.sv
module serial_wr_port
  import wrsp_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              addr_sel,
  input  logic              sdi,
  output logic              sclk_o,
  output logic              sclk_oe,
  output logic [WORD_W-1:0] ctrl_reg,
  output logic [WORD_W-1:0] cal_reg
);
  localparam int NREG = 2;

  wr_state_t state_q;
  logic frame_q, addr_q;
  logic start, run, rise_stb, fall_stb, last;
  logic [WORD_W-1:0] word_next;
  logic [NREG-1:0][WORD_W-1:0] regs;

  assign start = (state_q == ST_IDLE) && frame_q && !frame_n;
  assign run   = (state_q == ST_RUN) || (state_q == ST_TAIL);

  wrsp_sclk_gen #(.DIV(DIV)) u_clkgen (
    .clk(clk), .rst(rst), .run(run),
    .sclk_o(sclk_o), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  wrsp_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .clear(start),
    .shift_en(rise_stb && (state_q == ST_RUN)), .sdi(sdi),
    .word_next(word_next), .last(last)
  );

  wrsp_reg_bank #(.W(WORD_W), .NREG(NREG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(last), .sel(addr_q),
    .data(word_next), .regs(regs)
  );

  assign ctrl_reg = regs[0];
  assign cal_reg  = regs[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      frame_q <= 1'b0;
      addr_q  <= 1'b0;
      sclk_oe <= 1'b0;
    end else begin
      frame_q <= frame_n;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          addr_q  <= addr_sel;
          sclk_oe <= 1'b1;
        end
        ST_RUN:  if (last) state_q <= ST_TAIL;
        ST_TAIL: if (fall_stb) state_q <= ST_STOP;
        default: begin
          sclk_oe <= 1'b0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_wr_port_chk.sv
module serial_wr_port_chk #(
  parameter int DIV    = 8,
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_n,
  input logic              sclk_o,
  input logic              sclk_oe,
  input logic [WORD_W-1:0] ctrl_reg,
  input logic [WORD_W-1:0] cal_reg
);
  localparam int HI = DIV - DIV / 2;
  int unsigned hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)         hi_cnt <= 0;
    else if (sclk_o) hi_cnt <= hi_cnt + 1;
    else             hi_cnt <= 0;
  end

  assert_idle_low_R7: assert property (@(posedge clk) disable iff (rst)
    !sclk_oe |-> !sclk_o);
  assert_start_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_oe) |-> $past(!frame_n));
  assert_high_time_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> hi_cnt == HI);
  assert_one_target_R5: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(ctrl_reg) && !$stable(cal_reg)));
  assert_write_at_rise_R6: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ctrl_reg) || !$stable(cal_reg)) |-> (sclk_oe && $rose(sclk_o)));
  assert_oe_after_low_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_oe) |-> $past(!sclk_o));
endmodule

bind serial_wr_port serial_wr_port_chk #(.DIV(DIV), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_n), .sclk_o(sclk_o),
  .sclk_oe(sclk_oe), .ctrl_reg(ctrl_reg), .cal_reg(cal_reg)
);

// File: tb/serial_wr_port_tb_top.sv
`timescale 1ns/1ps
module serial_wr_port_tb_top;
  localparam int DIV = 8;
  localparam int W   = 24;

  logic clk = 1'b0, rst = 1'b1, frame_n = 1'b0, addr_sel = 1'b0, sdi = 1'b0;
  logic sclk_o, sclk_oe;
  logic [W-1:0] ctrl_reg, cal_reg;

  int n_tests = 0, n_fail = 0;
  logic [W:0] exp_q[$];

  always #2.5 clk = ~clk;

  serial_wr_port #(.DIV(DIV), .WORD_W(W)) dut_i (
    .clk(clk), .rst(rst), .frame_n(frame_n), .addr_sel(addr_sel), .sdi(sdi),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe), .ctrl_reg(ctrl_reg), .cal_reg(cal_reg)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: every register change pops the scoreboard (R5, R6)
  initial begin
    logic [W-1:0] pc, pk;
    pc = '0; pk = '0;
    forever begin
      @(negedge clk);
      if (!rst && (ctrl_reg != pc || cal_reg != pk)) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected write", ctrl_reg ^ cal_reg, 0);
        end else begin
          logic [W:0] e;
          e = exp_q.pop_front();
          if (e[W]) begin
            check(cal_reg == e[W-1:0], "R5 cal word", cal_reg, e[W-1:0]);
            check(ctrl_reg == pc, "R5 ctrl untouched", ctrl_reg, pc);
          end else begin
            check(ctrl_reg == e[W-1:0], "R5 ctrl word", ctrl_reg, e[W-1:0]);
            check(cal_reg == pk, "R5 cal untouched", cal_reg, pk);
          end
        end
      end
      pc = ctrl_reg; pk = cal_reg;
    end
  end

  task automatic write_word(input logic a, input logic [W-1:0] d, input bit glitch);
    int rises = 0, bad_per = 0, cyc = 0, last_rise = 0, guard = 0, tail = 0, extra = 0;
    logic prev_hi = 1'b0;
    logic [W-1:0] old_t;
    @(negedge clk);
    old_t = a ? cal_reg : ctrl_reg;
    exp_q.push_back({a, d});
    addr_sel = a; sdi = d[W-1]; frame_n = 1'b0;
    while (rises < W && guard < 40 * DIV * W) begin
      @(negedge clk); cyc++; guard++;
      if (sclk_o && !prev_hi) begin
        rises++;
        if (rises > 1 && cyc - last_rise != DIV) bad_per++;
        last_rise = cyc;
        if (glitch && rises == 10) frame_n = 1'b1;
        if (glitch && rises == 15) frame_n = 1'b0;
        if (rises == 12)
          check((a ? cal_reg : ctrl_reg) == old_t, "R6 target held mid-word",
                a ? cal_reg : ctrl_reg, old_t);
      end
      if (!sclk_o && prev_hi && rises < W) sdi = d[W-1-rises];
      prev_hi = sclk_o;
    end
    check(rises == W, "R4 rising edges per word", rises, W);
    check(bad_per == 0, "R3 clock period", bad_per, 0);
    while (sclk_oe && tail < 4 * DIV) begin
      @(negedge clk); tail++;
      if (sclk_o && !prev_hi) extra++;
      prev_hi = sclk_o;
    end
    check(tail == DIV - DIV / 2 + 1, "R7 cycles to disable", tail, DIV - DIV / 2 + 1);
    check(extra == 0, "R4 no extra edge", extra, 0);
    check(sclk_o == 1'b0, "R7 clock low when disabled", sclk_o, 0);
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      if (sclk_oe || sclk_o) extra++;
    end
    check(extra == 0, "R8 held low starts nothing", extra, 0);
    check(exp_q.size() == 0, "R6 word written", exp_q.size(), 0);
    frame_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    check(sclk_oe == 0 && sclk_o == 0, "R1 reset clock off", {sclk_oe, sclk_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ctrl_reg == 0 && cal_reg == 0, "R1 reset registers", ctrl_reg | cal_reg, 0);
    seen = 0;
    for (int i = 0; i < 5 * DIV; i++) begin
      @(negedge clk);
      if (sclk_oe) seen++;
    end
    check(seen == 0, "R2 low through reset is no start", seen, 0);
    frame_n = 1'b1;
    repeat (3) @(negedge clk);
    write_word(1'b0, 24'hA5C3F1, 0);
    write_word(1'b1, 24'h0F1E2D, 0);
    write_word(1'b0, 24'h800001, 0);
    write_word(1'b1, 24'hFFFFFF, 1);
    write_word(1'b0, 24'h000000, 1);
    write_word(1'b1, 24'h123456, 0);
    check(ctrl_reg == 24'h000000, "R5 final ctrl", ctrl_reg, 0);
    check(cal_reg == 24'h123456, "R5 final cal", cal_reg, 24'h123456);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule